// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides an input clock by a programmable integer N and marks the end of each division period with a one-cycle pulse. The division is built from a prescaler and two down-counters. In dual-modulus mode the prescaler uses a base modulus P, one of 2, 4, 8, 16 or 32. For the first A prescaler periods of each B-long count it divides by P+1, and for the rest it divides by P. The total division is therefore N = P×B + A. In fixed-divide mode the prescaler divides by 1, 2 or 3, the A input is ignored, and N = F×B.

A 3-bit select code picks the mode and the modulus. The A and B values and the select code are sampled only at the start of each period, so a new setting takes effect cleanly at the next period boundary. A setting that cannot be realised raises an error flag and holds the output low until a legal setting is presented. There is no data stream here: every pin is a plain control or status signal.

Top module: `dmd_divider`

## Requirements
- R1: With select code 3, 4, 5, 6 or 7 (dual-modulus, P = 2, 4, 8, 16, 32 in that order) and 0 < A ≤ B, the output pulses once every P×B + A input cycles.
- R2: With select code 0, 1 or 2 (fixed divide by 1, 2, 3 respectively) the period is F×B cycles. The A input has no effect, including A > B, and raises no error.
- R3: In dual-modulus mode with A = 0 the period is exactly P×B.
- R4: `pulse_o` is high for one cycle, in the last cycle of each period. Counting the first cycle after reset release as cycle 0, the first pulse falls in cycle N−1.
- R5: The select code, A and B are sampled at the start of each period. A change made in the middle of a period leaves that period's length unchanged and governs the next period.
- R6: If B = 0, or if A > B in dual-modulus mode, `err_o` is high and `pulse_o` stays low. Once a legal setting is applied, `err_o` falls at the next clock edge and a new period starts in that cycle.
- R7: A synchronous reset `rst` restarts the period. While reset is held and N > 1, `pulse_o` is low. After release, the next pulse comes N−1 cycles later.
- R8: With select code 0 and B = 1 (N = 1), `pulse_o` is high in every cycle.
- R9: A = B is legal in dual-modulus mode and gives period (P+1)×B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; restarts the period |
| sel_i | input | 3 | Mode and modulus select: 0–2 fixed ÷1/÷2/÷3, 3–7 dual-modulus P = 2/4/8/16/32 |
| a_i | input | A_W (6) | Swallow count A; ignored in fixed-divide mode |
| b_i | input | B_W (13) | Main count B |
| pulse_o | output | 1 | One-cycle pulse in the last cycle of each period |
| err_o | output | 1 | High while the sampled setting is illegal |

## Verification
Directed settings cover each mode family on its own. The case N = 1 separates a pulse that is held high from a single-cycle pulse. Dual-modulus with A = 0 and with A = B marks the ends of the swallow range. A fixed-divide case with A larger than B shows that A is truly ignored in that mode. Random settings across all select codes, with B up to 24 and A up to B, compare the spacing of every pulse against N = P×B + A, which catches a wrong modulus, a swallow counted off by one, or A applied in the wrong mode. Separate sequences cover a mid-period change of setting, a mid-period reset, and the entry into and exit from the error state. Together they show whether sampling happens only at period boundaries.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  // Prescaler modulus never exceeds 33 (P = 32 plus one swallowed cycle).
  localparam int PRE_W = 6;

  typedef struct packed {
    logic             dual;  // 1: P/P+1 mode, 0: fixed divide
    logic [PRE_W-1:0] base;  // P or fixed divide value
  } psel_t;

  function automatic psel_t decode_sel(input logic [2:0] s);
    psel_t r;
    if (s < 3'd3) begin
      r.dual = 1'b0;
      r.base = PRE_W'(s) + PRE_W'(1);
    end else begin
      r.dual = 1'b1;
      r.base = PRE_W'(1) << (s - 3'd2);
    end
    return r;
  endfunction

endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          restart,
  input  logic [CW-1:0] modulus,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  assign wrap = (cnt == modulus - CW'(1));

  always_ff @(posedge clk) begin
    if (restart || wrap) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/dmd_period_ctl.sv
module dmd_period_ctl #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic           dual_in,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [A_W-1:0] a_left,
  output logic [B_W-1:0] b_left,
  output logic           last,
  output logic           swallow
);

  assign last    = (b_left == B_W'(1));
  assign swallow = (a_left != '0);

  always_ff @(posedge clk) begin
    if (load) begin
      a_left <= dual_in ? a_in : '0;
      b_left <= b_in;
    end else if (step) begin
      b_left <= b_left - B_W'(1);
      if (swallow) a_left <= a_left - A_W'(1);
    end
  end

endmodule

// File: rtl/dmd_divider.sv
module dmd_divider
  import dmd_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     sel_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           pulse_o,
  output logic           err_o
);

  localparam int CMP_W = (A_W > B_W) ? A_W : B_W;

  psel_t            sel_dec;
  logic             err_in;
  logic             dual_q;
  logic [PRE_W-1:0] base_q;
  logic             err_q;
  logic [PRE_W-1:0] pre_mod;
  logic [PRE_W-1:0] pre_cnt;
  logic             wrap;
  logic [A_W-1:0]   a_left;
  logic [B_W-1:0]   b_left;
  logic             last;
  logic             swallow;
  logic             period_end;
  logic             reload;

  always_comb begin
    sel_dec = decode_sel(sel_i);
    err_in  = (b_i == '0) ||
              (sel_dec.dual && (CMP_W'(a_i) > CMP_W'(b_i)));
  end

  assign period_end = wrap && last;
  assign reload     = rst || err_q || period_end;
  assign pre_mod    = base_q + PRE_W'(swallow);

  always_ff @(posedge clk) begin
    if (reload) begin
      dual_q <= sel_dec.dual;
      base_q <= sel_dec.base;
      err_q  <= err_in;
    end
  end

  dmd_prescaler #(.CW(PRE_W)) u_pre (
    .clk     (clk),
    .restart (rst || err_q),
    .modulus (pre_mod),
    .cnt     (pre_cnt),
    .wrap    (wrap)
  );

  dmd_period_ctl #(.A_W(A_W), .B_W(B_W)) u_ctl (
    .clk     (clk),
    .load    (reload),
    .step    (wrap),
    .dual_in (sel_dec.dual),
    .a_in    (a_i),
    .b_in    (b_i),
    .a_left  (a_left),
    .b_left  (b_left),
    .last    (last),
    .swallow (swallow)
  );

  assign pulse_o = period_end && !err_q;
  assign err_o   = err_q;

endmodule

// File: rtl/dmd_divider_chk.sv
module dmd_divider_chk #(
  parameter int A_W = 6,
  parameter int B_W = 13,
  parameter int PW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           pulse_o,
  input logic           err_o,
  input logic [PW-1:0]  pre_cnt,
  input logic [PW-1:0]  pre_mod,
  input logic [A_W-1:0] a_left,
  input logic [B_W-1:0] b_left
);

  localparam int CW = (A_W > B_W) ? A_W : B_W;

  // R6
  err_blocks_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !pulse_o);

  // R6
  b_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> (b_left != '0));

  // R1
  swallow_le_count_chk: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> (CW'(a_left) <= CW'(b_left)));

  // R4
  pre_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> (pre_cnt < pre_mod));

  // R4
  restart_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> (pre_cnt == '0));

endmodule

bind dmd_divider dmd_divider_chk #(.A_W(A_W), .B_W(B_W), .PW(dmd_pkg::PRE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pulse_o (pulse_o),
  .err_o   (err_o),
  .pre_cnt (pre_cnt),
  .pre_mod (pre_mod),
  .a_left  (a_left),
  .b_left  (b_left)
);

// File: tb/tb_dmd_divider.sv
module tb_dmd_divider;

  localparam int A_W = 6;
  localparam int B_W = 13;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2:0]     sel_i = '0;
  logic [A_W-1:0] a_i = '0;
  logic [B_W-1:0] b_i = B_W'(1);
  logic           pulse_o;
  logic           err_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dmd_divider #(.A_W(A_W), .B_W(B_W)) dut (
    .clk(clk), .rst(rst), .sel_i(sel_i), .a_i(a_i), .b_i(b_i),
    .pulse_o(pulse_o), .err_o(err_o)
  );

  function automatic int exp_n(input int s, input int a, input int b);
    int p;
    if (s >= 3) begin
      p = 1 << (s - 2);
      return p * b + a;
    end
    return (s + 1) * b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start(input int s, input int a, input int b);
    @(negedge clk);
    rst   = 1'b1;
    sel_i = 3'(s);
    a_i   = A_W'(a);
    b_i   = B_W'(b);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Samples cycles 0 .. periods*n-1 of a running period sequence.
  task automatic run_cycles(input int n, input int periods, input string req);
    for (int k = 0; k < periods * n; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(pulse_o == ((k % n) == n - 1), req, int'(pulse_o), int'((k % n) == n - 1));
      check(err_o == 1'b0, req, int'(err_o), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R7: reset state, N > 1
    sel_i = 3'd4; a_i = A_W'(1); b_i = B_W'(3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pulse_o == 1'b0, "R7", int'(pulse_o), 0);
    check(err_o == 1'b0, "R7", int'(err_o), 0);

    // R8: N = 1, A ignored
    start(0, 7, 1);
    run_cycles(1, 6, "R8");

    // R2: fixed /3, A > B ignored
    start(2, 9, 5);
    run_cycles(exp_n(2, 0, 5), 3, "R2");
    start(1, 63, 4);
    run_cycles(exp_n(1, 0, 4), 2, "R2");

    // R3: dual P=8, A=0
    start(5, 0, 4);
    run_cycles(exp_n(5, 0, 4), 3, "R3");

    // R9: A = B
    start(3, 6, 6);
    run_cycles(exp_n(3, 6, 6), 3, "R9");

    // R1: P = 32 with swallow
    start(7, 22, 25);
    run_cycles(exp_n(7, 22, 25), 2, "R1");

    // R1 / R2: random settings
    for (int t = 0; t < 20; t++) begin
      int s, a, b;
      s = int'($urandom_range(7, 0));
      b = int'($urandom_range(24, 1));
      a = (s >= 3) ? int'($urandom_range(b, 0)) : int'($urandom_range(63, 0));
      start(s, a, b);
      run_cycles(exp_n(s, a, b), 2, (s >= 3) ? "R1" : "R2");
    end

    // R5: mid-period change, N 13 -> 8
    start(4, 1, 3);
    for (int k = 0; k <= 28; k++) begin
      bit e;
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      e = (k == 12) || (k == 20) || (k == 28);
      check(pulse_o == e, "R5", int'(pulse_o), int'(e));
      if (k == 5) begin
        a_i = '0;
        b_i = B_W'(2);
      end
    end

    // R7: reset in mid-period
    start(3, 1, 4);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(pulse_o == 1'b0, "R7", int'(pulse_o), 0);
    end
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(pulse_o == 1'b0, "R7", int'(pulse_o), 0);
    end
    rst = 1'b0;
    run_cycles(exp_n(3, 1, 4), 2, "R7");

    // R6: A > B in dual mode, then recovery
    start(5, 5, 3);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(err_o == 1'b1, "R6", int'(err_o), 1);
      check(pulse_o == 1'b0, "R6", int'(pulse_o), 0);
    end
    a_i = A_W'(2);
    @(posedge clk);
    @(negedge clk);
    run_cycles(exp_n(5, 2, 3), 2, "R6");

    // R6: B = 0
    start(1, 0, 0);
    for (int k = 0; k < 5; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(err_o == 1'b1, "R6", int'(err_o), 1);
      check(pulse_o == 1'b0, "R6", int'(pulse_o), 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule